// File: doc/BRIEF.md
# Timer-Counter with Shared Prescaler

This block is an 8-bit up-counter for a small processor core. It runs in one of two modes. In timer mode it counts instruction cycles, where one instruction cycle is four system clocks. In counter mode it counts edges on an external input pin. The pin is first synchronised to the instruction cycle. Software reads and loads the count through a simple write strobe and data bus. When the count rolls over from all ones to zero, the block sets a sticky flag. Software clears that flag with a strobe.

A single 8-bit prescaler stage is shared. Either it divides the counter's input events, or it acts as a postscaler on the pulses that feed an external watchdog. It never does both at once. A control byte picks all of the following:
- the clock source,
- the counted edge,
- the prescaler owner,
- a 3-bit division ratio.

The ratio means something different for each owner. For the counter it divides by 2 to 8 powers of two, starting at 1:2. For the watchdog it covers 1:1 to 1:128. Loading the count clears the prescaler and holds the counter for two instruction cycles. A watchdog-clear strobe resets the prescaler while the watchdog owns it.

Top module: `tmr8_shared_scaler`

## Requirements
- R1: After reset the count reads 0, the flag is 0 and the control byte reads 8'hFF. The control byte fields are:
  - bit 5: source (0 = instruction cycles, 1 = pin edges)
  - bit 4: edge (0 = rising, 1 = falling)
  - bit 3: owner (0 = counter, 1 = watchdog)
  - bits 2:0: ratio

  Bits 7:6 are stored and read back.
- R2: With bit 5 = 0 and bit 3 = 1, the count grows by exactly one per instruction cycle of 4 clocks. Over any window of 4·N clocks, that is N increments, less any that are blocked.
- R3: A count write loads `cnt_wdata` at the next edge. It wins over an increment in the same cycle. It then blocks increments for the next 2 instruction-cycle boundaries, so N instruction cycles after a write give N−2 increments.
- R4: An increment from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed. A wrap in the same cycle as a clear leaves the flag set.
- R5: With bit 5 = 1, the pin is sampled once per instruction cycle through a 2-stage synchroniser. With bit 4 = 0 each rising edge adds one. With bit 4 = 1 each falling edge adds one.
- R6: With bit 3 = 0, the counter advances once per 2^(ratio+1) source events (1:2 to 1:256).
- R7: With bit 3 = 0, a count write clears the prescaler count.
- R8: With bit 3 = 1, `wdt_tick` is a one-clock pulse. It is raised together with every 2^ratio-th `wdt_osc_tick` pulse (1:1 to 1:128).
- R9: With bit 3 = 1, `wdt_clr` clears the prescaler. With bit 3 = 0, `wdt_clr` has no effect on the counter's division.
- R10: With bit 3 = 0, `wdt_tick` stays 0 whatever `wdt_osc_tick` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| cnt_rdata | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky rollover flag |
| ovf_clr | input | 1 | Clears the rollover flag |
| ext_in | input | 1 | External count pin |
| wdt_osc_tick | input | 1 | Watchdog base pulse, one clock wide |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_tick | output | 1 | Postscaled pulse to the watchdog |

## Verification
A count write and an instruction-cycle increment can land on the same clock edge. The write must win, and the two-cycle hold must then start from that edge. The bench provokes this by issuing the same load at each of the four clock offsets within an instruction cycle. In every case it expects the loaded value plus exactly three after five instruction cycles. If an increment leaked through, or the hold window were off by one cycle, at least one offset would show a different value.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned RATIO_W  = 3;
  localparam int unsigned PS_MAX_W = 16;

  typedef struct packed {
    logic [1:0]         spare;
    logic               src_ext;
    logic               edge_fall;
    logic               ps_to_wdt;
    logic [RATIO_W-1:0] ratio;
  } tmr8_ctl_t;

  localparam tmr8_ctl_t CTL_RESET = tmr8_ctl_t'(8'hFF);

  // Exponent of the division: owner-dependent offset on the ratio field.
  function automatic int unsigned ps_exp(input logic to_wdt,
                                         input logic [RATIO_W-1:0] ratio);
    int unsigned e;
    e = int'(ratio);
    if (!to_wdt) e = e + 1;
    return e;
  endfunction

  // True when the low k bits of the prescaler are all ones.
  function automatic logic ps_hit(input logic [PS_MAX_W-1:0] ps,
                                  input int unsigned k);
    logic hit;
    hit = 1'b1;
    for (int unsigned i = 0; i < PS_MAX_W; i++) begin
      if (i < k && !ps[i]) hit = 1'b0;
    end
    return hit;
  endfunction

  function automatic logic edge_match(input logic prev, input logic cur,
                                      input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction
endpackage

// File: rtl/tmr8_cyc_gen.sv
module tmr8_cyc_gen #(
  parameter int unsigned CYC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic inst_tick
);
  localparam int unsigned PH_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_DIV - 1);

  generate
    if (CYC_DIV > 1) begin : g_div
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ph_q <= '0;
        else if (ph_q == PH_LAST)  ph_q <= '0;
        else                       ph_q <= ph_q + 1'b1;
      end
      assign inst_tick = (ph_q == PH_LAST);
    end else begin : g_nodiv
      assign inst_tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/tmr8_ext_sync.sv
module tmr8_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_evt
);
  import tmr8_pkg::*;

  // sh_q[0] takes the pin; sh_q[STAGES-1] is the settled level,
  // sh_q[STAGES] the level one instruction cycle earlier.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '0;
    else if (adv) sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign edge_evt = adv & edge_match(sh_q[STAGES], sh_q[STAGES-1], fall_sel);
endmodule

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int unsigned PS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               to_wdt,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               tmr_evt,
  input  logic               wdt_base,
  input  logic               tmr_clr,
  input  logic               wdt_clr,
  input  logic               reassign,
  output logic               tmr_inc,
  output logic               wdt_tick
);
  logic [PS_W-1:0] ps_q;
  int unsigned     k;
  logic            hit;
  logic            step;
  logic            clr;

  always_comb begin
    k        = ps_exp(to_wdt, ratio);
    hit      = ps_hit(PS_MAX_W'(ps_q), k);
    step     = to_wdt ? wdt_base : tmr_evt;
    clr      = reassign | (to_wdt ? wdt_clr : tmr_clr);
    tmr_inc  = to_wdt ? tmr_evt : (tmr_evt & hit);
    wdt_tick = to_wdt & wdt_base & hit & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ps_q <= '0;
    else if (clr)  ps_q <= '0;
    else if (step) ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             inc_req,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             wrap_evt,
  output logic             cnt_inc,
  output logic             inh_active
);
  localparam int unsigned INH_W = $clog2(INH_CYC + 1);
  logic [INH_W-1:0] inh_q;

  assign inh_active = (inh_q != '0);
  assign cnt_inc    = inc_req & ~wr;
  assign wrap_evt   = cnt_inc & (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr)      cnt_q <= wdata;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          inh_q <= '0;
    else if (wr)                         inh_q <= INH_W'(INH_CYC);
    else if (inst_tick && inh_active)    inh_q <= inh_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (wrap_evt)  flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/tmr8_shared_scaler.sv
module tmr8_shared_scaler
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PS_W        = 8,
  parameter int unsigned CYC_DIV     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned INH_CYC     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             ovf_flag,
  input  logic             ovf_clr,
  input  logic             ext_in,
  input  logic             wdt_osc_tick,
  input  logic             wdt_clr,
  output logic             wdt_tick
);
  tmr8_ctl_t ctl_q;
  tmr8_ctl_t ctl_nx;
  logic      inst_tick;
  logic      ext_evt;
  logic      src_evt;
  logic      src_gate;
  logic      reassign;
  logic      tmr_inc;
  logic      cnt_inc;
  logic      inh_active;
  logic      wrap_evt;

  assign ctl_nx   = tmr8_ctl_t'(ctl_wdata);
  assign reassign = ctl_wr & (ctl_nx.ps_to_wdt != ctl_q.ps_to_wdt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RESET;
    else if (ctl_wr) ctl_q <= ctl_nx;
  end
  assign ctl_rdata = ctl_q;

  tmr8_cyc_gen #(.CYC_DIV(CYC_DIV)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .inst_tick (inst_tick)
  );

  tmr8_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (inst_tick),
    .pin      (ext_in),
    .fall_sel (ctl_q.edge_fall),
    .edge_evt (ext_evt)
  );

  // Source events are held back during the post-write hold window
  // and in the write cycle itself, before they reach the prescaler.
  assign src_evt  = ctl_q.src_ext ? ext_evt : inst_tick;
  assign src_gate = src_evt & ~inh_active & ~cnt_wr;

  tmr8_prescale #(.PS_W(PS_W)) u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .to_wdt   (ctl_q.ps_to_wdt),
    .ratio    (ctl_q.ratio),
    .tmr_evt  (src_gate),
    .wdt_base (wdt_osc_tick),
    .tmr_clr  (cnt_wr),
    .wdt_clr  (wdt_clr),
    .reassign (reassign),
    .tmr_inc  (tmr_inc),
    .wdt_tick (wdt_tick)
  );

  tmr8_count #(.CNT_W(CNT_W), .INH_CYC(INH_CYC)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inst_tick  (inst_tick),
    .wr         (cnt_wr),
    .wdata      (cnt_wdata),
    .inc_req    (tmr_inc),
    .flag_clr   (ovf_clr),
    .cnt_q      (cnt_rdata),
    .flag_q     (ovf_flag),
    .wrap_evt   (wrap_evt),
    .cnt_inc    (cnt_inc),
    .inh_active (inh_active)
  );
endmodule

// File: rtl/tmr8_shared_scaler_chk.sv
module tmr8_shared_scaler_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             cnt_inc,
  input logic             inh_active,
  input logic             inst_tick,
  input logic             wrap_evt,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic [7:0]       ctl_rdata,
  input logic             wdt_tick,
  input logic             wdt_osc_tick
);
  AST_INC_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) cnt_inc |-> inst_tick); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (cnt_inc && !cnt_wr) |=> (cnt_rdata == CNT_W'($past(cnt_rdata) + 1'b1))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cnt_inc && !cnt_wr) |=> $stable(cnt_rdata)); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n) cnt_wr |=> (cnt_rdata == $past(cnt_wdata))); // R3
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) inh_active |-> !cnt_inc); // R3
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wrap_evt |=> ovf_flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag && !ovf_clr) |=> ovf_flag); // R4
  AST_WDT_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n) wdt_tick |-> wdt_osc_tick); // R8
  AST_WDT_GATED: assert property (@(posedge clk) disable iff (!rst_n) !ctl_rdata[3] |-> !wdt_tick); // R10
endmodule

bind tmr8_shared_scaler tmr8_shared_scaler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_wr       (cnt_wr),
  .cnt_wdata    (cnt_wdata),
  .cnt_rdata    (cnt_rdata),
  .cnt_inc      (cnt_inc),
  .inh_active   (inh_active),
  .inst_tick    (inst_tick),
  .wrap_evt     (wrap_evt),
  .ovf_flag     (ovf_flag),
  .ovf_clr      (ovf_clr),
  .ctl_rdata    (ctl_rdata),
  .wdt_tick     (wdt_tick),
  .wdt_osc_tick (wdt_osc_tick)
);

// File: tb/tmr8_shared_scaler_bench.sv
`timescale 1ns/1ps
module tmr8_shared_scaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt_rdata;
  logic       ovf_flag;
  logic       ovf_clr = 1'b0;
  logic       ext_in = 1'b0;
  logic       wdt_osc_tick = 1'b0;
  logic       wdt_clr = 1'b0;
  logic       wdt_tick;

  int total = 0;
  int bad = 0;
  int wdt_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_shared_scaler u_tmr8_shared_scaler (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .ext_in(ext_in), .wdt_osc_tick(wdt_osc_tick), .wdt_clr(wdt_clr),
    .wdt_tick(wdt_tick)
  );

  always @(posedge clk) if (wdt_tick) wdt_seen++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk) begin ctl_wr = 1'b1; ctl_wdata = v; end
    @(negedge clk) ctl_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk) begin cnt_wr = 1'b1; cnt_wdata = v; end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic run_clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic osc_pulses(input int m);
    repeat (m) begin
      @(negedge clk) wdt_osc_tick = 1'b1;
      @(negedge clk) wdt_osc_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_wdt_clr();
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
  endtask

  task automatic ext_hold(input logic lvl, input int n);
    @(negedge clk) ext_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  // k full pulses followed by a final rise: k+1 rising, k falling edges.
  task automatic ext_train(input int k);
    for (int i = 0; i < k; i++) begin
      ext_hold(1'b1, 32);
      ext_hold(1'b0, 32);
    end
    ext_hold(1'b1, 64);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", cnt_rdata, 0);
    chk("R1 flag after reset", ovf_flag, 0);
    chk("R1 control after reset", ctl_rdata, 8'hFF);

    // R2: timer mode, prescaler on the watchdog so the counter runs 1:1.
    set_ctl(8'hC8);
    chk("R1 control readback", ctl_rdata, 8'hC8);
    wr_cnt(8'h00);
    run_clks(4 * 52);
    chk("R2 one per instruction cycle", cnt_rdata, 50);

    // R3: hold of two instruction cycles after a load.
    wr_cnt(8'h10);
    run_clks(8);
    chk("R3 held two cycles", cnt_rdata, 8'h10);
    run_clks(3);
    run_clks(0);
    chk("R3 resumes after hold", cnt_rdata, 8'h11);

    // R3: load at every clock offset inside an instruction cycle.
    for (int off = 0; off < 4; off++) begin
      repeat (off) @(negedge clk);
      wr_cnt(8'h40);
      run_clks(20);
      chk($sformatf("R3 load at offset %0d", off), cnt_rdata, 8'h43);
    end

    // R4: rollover, stickiness and clear.
    pulse_ovf_clr();
    chk("R4 flag cleared", ovf_flag, 0);
    wr_cnt(8'hFD);
    run_clks(20);
    chk("R4 wrap value", cnt_rdata, 0);
    chk("R4 flag set on wrap", ovf_flag, 1);
    run_clks(16);
    chk("R4 count after wrap", cnt_rdata, 4);
    chk("R4 flag sticky", ovf_flag, 1);
    pulse_ovf_clr();
    chk("R4 flag clear strobe", ovf_flag, 0);

    // R6: prescaler on the counter, every ratio.
    for (int r = 0; r < 8; r++) begin
      int n;
      n = 2 + 3 * (1 << (r + 1)) + r;
      set_ctl(8'hC0 | 8'(r));
      wr_cnt(8'h00);
      run_clks(4 * n);
      chk($sformatf("R6 ratio %0d", r), cnt_rdata, 3);
    end

    // R7: a load clears a partly filled prescaler (ratio 2 -> 1:8).
    set_ctl(8'hC2);
    wr_cnt(8'h00);
    run_clks(4 * 15);
    chk("R7 first pass", cnt_rdata, 1);
    wr_cnt(8'h00);
    run_clks(4 * 13);
    chk("R7 prescaler cleared by load", cnt_rdata, 1);

    // R9: watchdog clear ignored while the counter owns the prescaler.
    wr_cnt(8'h00);
    repeat (20) @(posedge clk);
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
    run_clks(19);
    chk("R9 clear ignored when counter owns", cnt_rdata, 1);

    // R5: external edges, rising and falling.
    ext_hold(1'b0, 64);
    set_ctl(8'hE8);
    wr_cnt(8'h00);
    run_clks(40);
    ext_train(5);
    chk("R5 rising edges", cnt_rdata, 6);
    ext_hold(1'b0, 64);
    set_ctl(8'hF8);
    wr_cnt(8'h00);
    run_clks(40);
    ext_train(5);
    chk("R5 falling edges", cnt_rdata, 5);
    ext_hold(1'b0, 64);
    set_ctl(8'hE0);
    wr_cnt(8'h00);
    run_clks(40);
    ext_train(5);
    chk("R6 pin edges through 1:2", cnt_rdata, 3);
    ext_hold(1'b0, 64);

    // R8: watchdog postscaler, every ratio.
    for (int r = 0; r < 8; r++) begin
      set_ctl(8'hC8 | 8'(r));
      pulse_wdt_clr();
      @(negedge clk) wdt_seen = 0;
      osc_pulses(200);
      chk($sformatf("R8 ratio %0d", r), wdt_seen, 200 >> r);
    end

    // R9: watchdog clear resets the postscaler (ratio 3 -> 1:8).
    set_ctl(8'hCB);
    pulse_wdt_clr();
    @(negedge clk) wdt_seen = 0;
    osc_pulses(5);
    pulse_wdt_clr();
    osc_pulses(7);
    chk("R9 clear restarts postscaler", wdt_seen, 0);
    osc_pulses(1);
    chk("R9 tick after full count", wdt_seen, 1);

    // R10: no watchdog pulses while the counter owns the prescaler.
    set_ctl(8'hC0);
    @(negedge clk) wdt_seen = 0;
    osc_pulses(50);
    chk("R10 watchdog gated off", wdt_seen, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule